// File: doc/BRIEF.md
# SDRAM Mode-Set and Power-Down Controller

This block sits in a memory bus controller that serves two SDRAM chip-select areas. A write from the processor into one of two reserved 4 KiB address windows becomes a Mode Register Set command on the SDRAM pins for the area that owns that window. The mode value is the address offset inside the window, placed on the SDRAM address lines. The block has no data input because the mode-set access carries no payload.

The block also manages clock-enable power-down. A configuration write sets an idle limit. After that many consecutive quiet cycles, the block drops CKE. A request that arrives while CKE is low costs one extra cycle, in which CKE is raised again before the command goes out. Until the configuration has been written once after reset, mode-set requests are refused with an error.

Top module: `sdram_mrs_ctl`

## Requirements
- R1: An address with bits [31:12] equal to 0xA4FD4 selects area 2, which pulls `cs_n[0]` low. An address with bits [31:12] equal to 0xA4FD5 selects area 3, which pulls `cs_n[1]` low. The chip select of the other area stays high for the whole sequence.
- R2: During the command cycle, `sd_addr` carries bits [11:0] of the request address.
- R3: The Mode Register Set command is one cycle with the selected chip select, `ras_n`, `cas_n` and `we_n` all low. In that cycle `cke` is high and every `dqm` bit is high.
- R4: The command cycle is followed by two NOP cycles: the selected chip select low and `ras_n`, `cas_n` and `we_n` high. In the next cycle `ack` is high for one cycle with `err` low and all chip selects high.
- R5: Until the first configuration write after reset, a request is refused. `ack` and `err` are high together for one cycle, no chip select goes low, and `cke` keeps its value.
- R6: A read (`req_we` low) is refused in the same way as in R5, and so is an address outside both windows. This holds while powered down as well, and `cke` then stays low.
- R7: After a configuration write with idle limit N > 0, `cke` falls after N consecutive cycles with no request and no `ack`. The first such cycle is the one after the configuration write. An idle limit of 0 never powers down.
- R8: A request accepted while `cke` is low first produces one wake cycle. In that cycle `cke` is high, the selected chip select is low with `ras_n`, `cas_n` and `we_n` high, and `dqm` is all ones. The command cycle follows.
- R9: A request that is present in the cycle where the idle count would expire prevents the power-down. The command cycle then follows directly, with no wake cycle.
- R10: After reset, `cke` is high, all chip selects, `ras_n`, `cas_n` and `we_n` are high, `dqm` is zero, and `ack` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idle | input | IDLE_W | Idle limit for power-down, 0 disables it |
| req | input | 1 | Request, held until `ack` |
| req_we | input | 1 | Request is a write |
| req_addr | input | 32 | Request address |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused, valid with `ack` |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 2 | Chip selects, bit 0 for area 2, bit 1 for area 3 |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| dqm | output | DQM_W | Data mask |
| sd_addr | output | MA_W | SDRAM address lines |

## Verification
Two functions can fall in the same clock edge: the idle counter reaching its limit, and a new request arriving. To provoke this, the bench counts idle cycles after a completed command and raises `req` so that it is sampled at exactly the edge where the counter would expire. The result is judged at the pins. The first cycle after acceptance must already be the command cycle with `cke` high, not a wake cycle. A neighbouring test starts the request after the power-down has happened and checks that the wake cycle does appear.

// File: rtl/sdram_mrs_ctl.sv
module sdram_mrs_ctl #(
  parameter logic [31:0] AREA2_BASE = 32'hA4FD_4000,
  parameter logic [31:0] AREA3_BASE = 32'hA4FD_5000,
  parameter int MA_W   = 12,
  parameter int IDLE_W = 8,
  parameter int TMRD   = 2,
  parameter int DQM_W  = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              req,
  input  logic              req_we,
  input  logic [31:0]       req_addr,
  output logic              ack,
  output logic              err,
  output logic              cke,
  output logic [1:0]        cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DQM_W-1:0]  dqm,
  output logic [MA_W-1:0]   sd_addr
);
  localparam int TW = $clog2(TMRD + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_MRS, S_TMRD} st_t;

  st_t              st;
  logic             area;
  logic [MA_W-1:0]  mode;
  logic [TW-1:0]    tcnt;
  logic             cfg_done;
  logic [IDLE_W-1:0] idle_lim, idle_cnt;

  wire hit2 = req_addr[31:MA_W] == AREA2_BASE[31:MA_W];
  wire hit3 = req_addr[31:MA_W] == AREA3_BASE[31:MA_W];
  wire take = (st == S_IDLE) && req && !ack;
  wire ok   = cfg_done && req_we && (hit2 || hit3);
  wire idle_tick = (st == S_IDLE) && !req && !ack && cke && cfg_done && (idle_lim != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      area <= 1'b0;
      mode <= '0;
      tcnt <= '0;
      cfg_done <= 1'b0;
      idle_lim <= '0;
      idle_cnt <= '0;
      cke <= 1'b1;
      ack <= 1'b0;
      err <= 1'b0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (take) begin
            if (ok) begin
              area <= hit3;
              mode <= req_addr[MA_W-1:0];
              if (!cke) begin
                cke <= 1'b1;
                st  <= S_WAKE;
              end else begin
                st  <= S_MRS;
              end
            end else begin
              ack <= 1'b1;
              err <= 1'b1;
            end
          end
          if (idle_tick) begin
            if (idle_cnt == idle_lim - 1'b1) begin
              cke <= 1'b0;
              idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end else begin
            idle_cnt <= '0;
          end
        end
        S_WAKE: st <= S_MRS;
        S_MRS: begin
          st   <= S_TMRD;
          tcnt <= '0;
        end
        S_TMRD: begin
          if (tcnt == TW'(TMRD - 1)) begin
            st  <= S_IDLE;
            ack <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (cfg_we) begin
        cfg_done <= 1'b1;
        idle_lim <= cfg_idle;
        idle_cnt <= '0;
      end
    end
  end

  wire busy = st != S_IDLE;
  assign cs_n    = busy ? (area ? 2'b01 : 2'b10) : 2'b11;
  assign ras_n   = st != S_MRS;
  assign cas_n   = st != S_MRS;
  assign we_n    = st != S_MRS;
  assign dqm     = {DQM_W{(st == S_WAKE) || (st == S_MRS)}};
  assign sd_addr = (st == S_MRS) ? mode : '0;

  wire mrs_on = !ras_n && !cas_n && !we_n && (cs_n != 2'b11);

  // R3
  mrs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_on |=> !mrs_on);
  // R3
  mrs_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_on |-> (cke && (&dqm)));
  // R1
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  // R4
  ack_after_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err) |-> $past(ras_n && (cs_n != 2'b11)));
  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ack && cs_n == 2'b11 && $stable(cke)));
  // R8
  wake_then_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> mrs_on);
  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cs_n == 2'b11 && !ack));
endmodule

// File: tb/sim_sdram_mrs_ctl.sv
module sim_sdram_mrs_ctl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_we, req, req_we;
  logic [7:0]  cfg_idle;
  logic [31:0] req_addr;
  logic        ack, err, cke, ras_n, cas_n, we_n;
  logic [1:0]  cs_n;
  logic [3:0]  dqm;
  logic [11:0] sd_addr;

  sdram_mrs_ctl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idle(cfg_idle),
    .req(req), .req_we(req_we), .req_addr(req_addr),
    .ack(ack), .err(err), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .sd_addr(sd_addr)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pins();
    return {cke, cs_n, ras_n, cas_n, we_n, dqm};
  endfunction

  task automatic t_reset;
    chk(cke && cs_n == 2'b11 && ras_n && cas_n && we_n && dqm == 4'h0 && !ack && !err,
        "R10 reset pins", pins(), {1'b1, 2'b11, 3'b111, 4'h0});
  endtask

  task automatic mrs(input logic [31:0] a, input bit wake);
    logic [1:0] csx;
    csx = (a[31:12] == 20'hA4FD5) ? 2'b01 : 2'b10;
    req = 1; req_we = 1; req_addr = a;
    tick;
    if (wake) begin
      chk(cke && cs_n == csx && ras_n && cas_n && we_n && dqm == 4'hF,
          "R8 wake cycle", pins(), {1'b1, csx, 3'b111, 4'hF});
      tick;
    end
    chk(cs_n == csx, "R1 area select", cs_n, csx);
    chk(!ras_n && !cas_n && !we_n && cke && dqm == 4'hF,
        "R3 mrs command", pins(), {1'b1, csx, 3'b000, 4'hF});
    chk(sd_addr == a[11:0], "R2 mode on address", sd_addr, a[11:0]);
    tick;
    for (int i = 0; i < 2; i++) begin
      chk(cs_n == csx && ras_n && cas_n && we_n && !ack,
          "R4 nop after mrs", pins(), {1'b1, csx, 3'b111, 4'h0});
      tick;
    end
    chk(ack && !err && cs_n == 2'b11, "R4 ack pulse", {ack, err, cs_n}, 4'b1011);
    req = 0;
    tick;
    chk(!ack, "R4 ack one cycle", ack, 0);
  endtask

  task automatic reject(input logic [31:0] a, input bit we, input string r);
    logic c0;
    c0 = cke;
    req = 1; req_we = we; req_addr = a;
    tick;
    chk(ack && err, r, {ack, err}, 2'b11);
    chk(cs_n == 2'b11 && ras_n && cke == c0, r, pins(), {c0, 2'b11, 3'b111, 4'h0});
    req = 0;
    tick;
    chk(!ack && !err && cs_n == 2'b11 && cke == c0, r, pins(), {c0, 2'b11, 3'b111, 4'h0});
  endtask

  task automatic cfg(input int n);
    cfg_we = 1; cfg_idle = 8'(n);
    tick;
    cfg_we = 0;
  endtask

  task automatic t_nopd;
    bit stayed;
    stayed = 1;
    cfg(0);
    repeat (30) begin
      tick;
      if (!cke) stayed = 0;
    end
    chk(stayed, "R7 limit 0 never powers down", stayed, 1);
  endtask

  task automatic t_pd(input int n);
    cfg(n);
    for (int i = 1; i < n; i++) begin
      tick;
      chk(cke, "R7 cke high before limit", cke, 1);
    end
    tick;
    chk(!cke && cs_n == 2'b11, "R7 cke falls at limit", pins(), {1'b0, 2'b11, 3'b111, 4'h0});
  endtask

  task automatic wait_pd;
    for (int i = 0; i < 40; i++) begin
      if (!cke) break;
      tick;
    end
    chk(!cke, "R7 power-down reached", cke, 0);
  endtask

  task automatic t_collide(input int n, input logic [31:0] a);
    for (int i = 1; i < n; i++) tick;
    chk(cke, "R9 cke high before collision", cke, 1);
    mrs(a, 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idle = 0; req = 0; req_we = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    reject(32'hA4FD_4010, 1, "R5 refused before config");
    t_nopd;
    mrs(32'hA4FD_4232, 0);
    mrs(32'hA4FD_5031, 0);
    mrs(32'hA4FD_5FFF, 0);
    mrs(32'hA4FD_4000, 0);
    reject(32'hA4FD_4100, 0, "R6 read refused");
    reject(32'hA4FD_6000, 1, "R6 above windows refused");
    reject(32'hA4FD_3FFF, 1, "R6 below windows refused");
    t_pd(5);
    mrs(32'hA4FD_4123, 1);
    wait_pd;
    reject(32'hA4FD_5001, 0, "R6 refused while powered down");
    mrs(32'hA4FD_5ABC, 1);
    t_collide(5, 32'hA4FD_4555);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1;
    $finish;
  end
endmodule